// File: doc/BRIEF.md
# Programmable Serial Lane Bit Mapper

This block stands just ahead of the serializer of a two-channel data converter output. On every input strobe it takes one 20-bit sample for each channel, A and B. It then builds one parallel frame word in which each output position carries a sample bit chosen by software. Position 0 of `frame_o` is the first bit sent. Each position has its own 7-bit source identifier. The identifier names the channel, the sample age (current, or the sample from the strobe before) and the bit index. The block keeps one previous sample per channel, so that two-sample frames can send older bits next to newer ones.

There are three lane layouts, and each has its own identifier table. In the two-wire layout each channel drives two lanes of 20 positions, which gives 80 positions. In the one-wire layout each channel drives one lane of 20 positions. In the half-wire layout both channels share one lane of 40 positions. Software programs a position by writing an identifier to an address whose upper field picks the layout table and whose lower field picks the position. The frame output is registered, so each frame appears one cycle after its strobe.

Top module: `lane_bit_mapper`

## Requirements
- R1: An identifier id drives its position with a sample bit as follows. id[6]=1 selects the current sample. id[2]=1 selects channel A and 0 selects channel B. The index code n = 4*id[5:3] + id[1:0] selects bit n-2, which is valid for n from 2 to 21. For example, 0x6D is current D19 of channel A and 0x51 is current D7 of channel B.
- R2: In the two-wire layout (lane_mode_i=0), an identifier with id[6]=0 drives the named bit of the sample that arrived at the previous input strobe.
- R3: In the one-wire layout (lane_mode_i=1) and the half-wire layout (lane_mode_i=2), an identifier with id[6]=0 drives its position to 0.
- R4: An identifier whose index code n lies outside 2..21 drives its position to 0 (for example 0x7F, 0x30, 0x01, 0x2E, 0x00).
- R5: After reset, every table holds the current samples MSB first. In the one-wire and half-wire tables, positions 0..19 carry A D19..D0 and positions 20..39 carry B D19..D0. In the two-wire table the 20-position lanes, in order, carry current A, previous A, current B and previous B, each MSB first.
- R6: frame_valid_o is high in exactly the cycle after each cycle in which in_valid_i is high. frame_o keeps its value while no strobe arrives.
- R7: In the one-wire and half-wire layouts, positions 40..79 are 0. With lane_mode_i=3 every position is 0.
- R8: A write with wr_en_i puts wr_id_i into table wr_addr_i[8:7] (0 two-wire, 1 one-wire, 2 half-wire) at position wr_addr_i[6:0]. A write to table 3, or to a position at or above the depth of its table (80 or 40), changes nothing, and a write to one table leaves the other tables unchanged.
- R9: A write applies to strobes from the next cycle on. A strobe in the same cycle as a write uses the table as it was before the write.
- R10: The previous-sample history is 0 after reset and is updated on every strobe, in any layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Sample strobe |
| sample_a_i | input | 20 | Channel A sample |
| sample_b_i | input | 20 | Channel B sample |
| lane_mode_i | input | 2 | Layout: 0 two-wire, 1 one-wire, 2 half-wire, 3 off |
| wr_en_i | input | 1 | Table write enable |
| wr_addr_i | input | 9 | Table select [8:7], position [6:0] |
| wr_id_i | input | 7 | Source identifier to store |
| frame_valid_o | output | 1 | Frame word valid |
| frame_o | output | 80 | Frame word, bit p = position p |

## Verification
The properties assume that in_valid_i and lane_mode_i carry known values at every rising edge. They also assume that the layout applied to a frame is the one present on the strobe that produced it, and they take no account of how the tables were programmed. The stimulus changes all inputs only on falling edges and holds lane_mode_i next to each strobe, so every sampled value is settled. The stimulus mixes back-to-back strobes, idle gaps, writes that share a cycle with a strobe, and identifiers drawn from both the valid and the invalid code ranges.

// File: rtl/lbm_pkg.sv
package lbm_pkg;

    localparam int ID_W = 7;

    typedef logic [ID_W-1:0] bit_id_t;

    typedef enum logic [1:0] {
        MODE_TWO  = 2'd0,
        MODE_ONE  = 2'd1,
        MODE_HALF = 2'd2,
        MODE_OFF  = 2'd3
    } lane_mode_e;

    // Build an identifier: age bit, upper index code, channel bit, lower index code.
    function automatic bit_id_t make_id(input logic cur, input logic chan_a, input int unsigned idx);
        logic [4:0] code;
        code = 5'(idx + 2);
        return {cur, code[4:2], chan_a, code[1:0]};
    endfunction

    // Reset content of a table entry: MSB-first identity per lane.
    function automatic bit_id_t default_id(input lane_mode_e m, input int unsigned pos,
                                           input int unsigned lane_pos);
        int unsigned lane;
        int unsigned idx;
        lane = pos / lane_pos;
        idx  = lane_pos - 1 - (pos % lane_pos);
        if (m == MODE_TWO) begin
            case (lane)
                0:       return make_id(1'b1, 1'b1, idx);
                1:       return make_id(1'b0, 1'b1, idx);
                2:       return make_id(1'b1, 1'b0, idx);
                3:       return make_id(1'b0, 1'b0, idx);
                default: return '0;
            endcase
        end
        case (lane)
            0:       return make_id(1'b1, 1'b1, idx);
            1:       return make_id(1'b1, 1'b0, idx);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/lbm_pos_table.sv
module lbm_pos_table
    import lbm_pkg::*;
#(
    parameter int MAXPOS   = 80,
    parameter int DEPTH    = 80,
    parameter int MODE     = 0,
    parameter int LANE_POS = 20,
    localparam int POS_W   = $clog2(MAXPOS)
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           wr_en_i,
    input  logic [POS_W-1:0]               wr_pos_i,
    input  bit_id_t                        wr_id_i,
    output logic [MAXPOS-1:0][ID_W-1:0]    tab_o
);

    logic [MAXPOS-1:0][ID_W-1:0] tab_d, tab_q;

    always_comb begin
        tab_d = tab_q;
        if (wr_en_i && (wr_pos_i < POS_W'(DEPTH))) begin
            tab_d[wr_pos_i] = wr_id_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int p = 0; p < MAXPOS; p++) begin
                tab_q[p] <= (p < DEPTH) ? default_id(lane_mode_e'(MODE), p, LANE_POS) : '0;
            end
        end else begin
            tab_q <= tab_d;
        end
    end

    assign tab_o = tab_q;

endmodule

// File: rtl/lbm_bit_pick.sv
module lbm_bit_pick
    import lbm_pkg::*;
#(
    parameter int SAMPLE_W = 20
) (
    input  bit_id_t             id_i,
    input  logic [SAMPLE_W-1:0] cur_a_i,
    input  logic [SAMPLE_W-1:0] cur_b_i,
    input  logic [SAMPLE_W-1:0] prev_a_i,
    input  logic [SAMPLE_W-1:0] prev_b_i,
    input  logic                prev_ok_i,
    output logic                bit_o
);

    localparam logic [4:0] CODE_LO = 5'd2;
    localparam logic [4:0] CODE_HI = 5'(SAMPLE_W + 1);

    logic [4:0]          code;
    logic [4:0]          idx;
    logic                in_range;
    logic [SAMPLE_W-1:0] src;

    always_comb begin
        code     = {id_i[5:3], id_i[1:0]};
        idx      = code - CODE_LO;
        in_range = (code >= CODE_LO) && (code <= CODE_HI);
        case ({id_i[6], id_i[2]})
            2'b11:   src = cur_a_i;
            2'b10:   src = cur_b_i;
            2'b01:   src = prev_a_i;
            default: src = prev_b_i;
        endcase
        bit_o = in_range && (id_i[6] || prev_ok_i) && src[idx];
    end

endmodule

// File: rtl/lane_bit_mapper.sv
module lane_bit_mapper
    import lbm_pkg::*;
#(
    parameter int  SAMPLE_W = 20,
    localparam int LANE_POS = SAMPLE_W,
    localparam int FRAME_W  = 4 * LANE_POS,
    localparam int HALF_W   = 2 * LANE_POS,
    localparam int POS_W    = $clog2(FRAME_W),
    localparam int ADDR_W   = POS_W + 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                in_valid_i,
    input  logic [SAMPLE_W-1:0] sample_a_i,
    input  logic [SAMPLE_W-1:0] sample_b_i,
    input  logic [1:0]          lane_mode_i,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   wr_addr_i,
    input  logic [ID_W-1:0]     wr_id_i,
    output logic                frame_valid_o,
    output logic [FRAME_W-1:0]  frame_o
);

    localparam int NUM_TAB = 3;

    typedef struct packed {
        logic [SAMPLE_W-1:0] prev_a;
        logic [SAMPLE_W-1:0] prev_b;
        logic [FRAME_W-1:0]  frame;
        logic                fvalid;
    } state_t;

    state_t st_d, st_q;

    lane_mode_e                  mode;
    logic                        prev_ok;
    logic [FRAME_W-1:0][ID_W-1:0] tab_w [NUM_TAB];
    logic [FRAME_W-1:0][ID_W-1:0] id_sel;
    logic [FRAME_W-1:0]          pick_w;

    assign mode    = lane_mode_e'(lane_mode_i);
    assign prev_ok = (mode == MODE_TWO);

    // One identifier table per lane layout; the two-wire table is full depth.
    for (genvar m = 0; m < NUM_TAB; m++) begin : g_tab
        lbm_pos_table #(
            .MAXPOS  (FRAME_W),
            .DEPTH   ((m == 0) ? FRAME_W : HALF_W),
            .MODE    (m),
            .LANE_POS(LANE_POS)
        ) u_tab (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .wr_en_i (wr_en_i && (wr_addr_i[ADDR_W-1 -: 2] == 2'(m))),
            .wr_pos_i(wr_addr_i[POS_W-1:0]),
            .wr_id_i (bit_id_t'(wr_id_i)),
            .tab_o   (tab_w[m])
        );
    end

    always_comb begin
        case (mode)
            MODE_TWO:  id_sel = tab_w[0];
            MODE_ONE:  id_sel = tab_w[1];
            MODE_HALF: id_sel = tab_w[2];
            default:   id_sel = '0;
        endcase
    end

    // Per-position source selection.
    for (genvar p = 0; p < FRAME_W; p++) begin : g_pick
        lbm_bit_pick #(
            .SAMPLE_W(SAMPLE_W)
        ) u_pick (
            .id_i     (id_sel[p]),
            .cur_a_i  (sample_a_i),
            .cur_b_i  (sample_b_i),
            .prev_a_i (st_q.prev_a),
            .prev_b_i (st_q.prev_b),
            .prev_ok_i(prev_ok),
            .bit_o    (pick_w[p])
        );
    end

    always_comb begin
        st_d        = st_q;
        st_d.fvalid = in_valid_i;
        if (in_valid_i) begin
            st_d.prev_a = sample_a_i;
            st_d.prev_b = sample_b_i;
            st_d.frame  = pick_w;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign frame_valid_o = st_q.fvalid;
    assign frame_o       = st_q.frame;

endmodule

// File: rtl/lbm_checker.sv
module lbm_checker #(
    parameter int FRAME_W = 80,
    parameter int HALF_W  = 40
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               in_valid_i,
    input logic [1:0]         lane_mode_i,
    input logic               frame_valid_o,
    input logic [FRAME_W-1:0] frame_o
);

    // R6: a strobe yields a valid frame in the next cycle
    assert_valid_follows_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i |=> frame_valid_o);

    // R6: no strobe, no valid frame
    assert_valid_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_valid_i |=> !frame_valid_o);

    // R6: frame held between strobes
    assert_frame_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_valid_i |=> $stable(frame_o));

    // R7: narrow layouts leave the upper positions at zero
    assert_narrow_upper_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && (lane_mode_i == 2'd1 || lane_mode_i == 2'd2))
            |=> (frame_o[FRAME_W-1:HALF_W] == '0));

    // R7: off layout yields an all-zero frame
    assert_off_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && lane_mode_i == 2'd3) |=> (frame_o == '0));

endmodule

bind lane_bit_mapper lbm_checker #(
    .FRAME_W(FRAME_W),
    .HALF_W (HALF_W)
) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .in_valid_i   (in_valid_i),
    .lane_mode_i  (lane_mode_i),
    .frame_valid_o(frame_valid_o),
    .frame_o      (frame_o)
);

// File: tb/lane_bit_mapper_tb_top.sv
`timescale 1ns/1ps
module lane_bit_mapper_tb_top;

    localparam int SW = 20;
    localparam int FW = 80;
    localparam int HW = 40;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic [SW-1:0] samp_a, samp_b;
    logic [1:0]    mode;
    logic          wr_en;
    logic [8:0]    wr_addr;
    logic [6:0]    wr_id;
    logic          fvalid;
    logic [FW-1:0] frame;

    always #4 clk = ~clk;

    lane_bit_mapper dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .in_valid_i   (in_valid),
        .sample_a_i   (samp_a),
        .sample_b_i   (samp_b),
        .lane_mode_i  (mode),
        .wr_en_i      (wr_en),
        .wr_addr_i    (wr_addr),
        .wr_id_i      (wr_id),
        .frame_valid_o(fvalid),
        .frame_o      (frame)
    );

    int checks = 0;
    int errors = 0;
    bit running = 0;

    logic [FW-1:0] exp_q[$];
    string         tag_q[$];
    logic [6:0]    m2[FW];
    logic [6:0]    m1[HW];
    logic [6:0]    mh[HW];
    logic [SW-1:0] pa, pb;
    logic [FW-1:0] last_exp;
    logic [31:0]   lf = 32'h1234_5679;

    function automatic logic [6:0] code_of(bit cur, bit cha, int k);
        logic [4:0] v;
        v = 5'(k + 2);
        return {cur, v[4:2], cha, v[1:0]};
    endfunction

    function automatic logic pick(logic [6:0] id, logic [SW-1:0] a, logic [SW-1:0] b, bit prev_ok);
        for (int k = 0; k < SW; k++) begin
            if (id == code_of(1, 1, k)) return a[k];
            if (id == code_of(1, 0, k)) return b[k];
            if (id == code_of(0, 1, k)) return prev_ok & pa[k];
            if (id == code_of(0, 0, k)) return prev_ok & pb[k];
        end
        return 1'b0;
    endfunction

    function automatic logic [FW-1:0] expect_frame(logic [SW-1:0] a, logic [SW-1:0] b, logic [1:0] md);
        logic [FW-1:0] e;
        logic [6:0]    id;
        e = '0;
        for (int p = 0; p < FW; p++) begin
            case (md)
                2'd0:    id = m2[p];
                2'd1:    id = (p < HW) ? m1[p] : 7'h00;
                2'd2:    id = (p < HW) ? mh[p] : 7'h00;
                default: id = 7'h00;
            endcase
            e[p] = (md == 2'd3) ? 1'b0 : pick(id, a, b, md == 2'd0);
        end
        return e;
    endfunction

    task automatic init_model();
        for (int p = 0; p < SW; p++) begin
            m2[p]        = code_of(1, 1, SW - 1 - p);
            m2[p + SW]   = code_of(0, 1, SW - 1 - p);
            m2[p + 2*SW] = code_of(1, 0, SW - 1 - p);
            m2[p + 3*SW] = code_of(0, 0, SW - 1 - p);
            m1[p]        = code_of(1, 1, SW - 1 - p);
            m1[p + SW]   = code_of(1, 0, SW - 1 - p);
            mh[p]        = code_of(1, 1, SW - 1 - p);
            mh[p + SW]   = code_of(1, 0, SW - 1 - p);
        end
        pa = '0;
        pb = '0;
    endtask

    task automatic model_write(int f, int pos, logic [6:0] id);
        if (f == 0 && pos < FW) m2[pos] = id;
        if (f == 1 && pos < HW) m1[pos] = id;
        if (f == 2 && pos < HW) mh[pos] = id;
    endtask

    task automatic check_eq(string tag, logic [FW-1:0] act, logic [FW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(logic [SW-1:0] a, logic [SW-1:0] b, logic [1:0] md, string tag);
        logic [FW-1:0] e;
        @(negedge clk);
        e = expect_frame(a, b, md);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        last_exp = e;
        pa = a;
        pb = b;
        in_valid = 1'b1;
        samp_a   = a;
        samp_b   = b;
        mode     = md;
        wr_en    = 1'b0;
    endtask

    task automatic wr(int f, int pos, logic [6:0] id);
        @(negedge clk);
        in_valid = 1'b0;
        wr_en    = 1'b1;
        wr_addr  = {2'(f), 7'(pos)};
        wr_id    = id;
        model_write(f, pos, id);
    endtask

    task automatic send_wr(logic [SW-1:0] a, logic [SW-1:0] b, logic [1:0] md,
                           int f, int pos, logic [6:0] id, string tag);
        logic [FW-1:0] e;
        @(negedge clk);
        e = expect_frame(a, b, md);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        last_exp = e;
        pa = a;
        pb = b;
        in_valid = 1'b1;
        samp_a   = a;
        samp_b   = b;
        mode     = md;
        wr_en    = 1'b1;
        wr_addr  = {2'(f), 7'(pos)};
        wr_id    = id;
        model_write(f, pos, id);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            wr_en    = 1'b0;
        end
    endtask

    function automatic logic [31:0] rnd();
        lf = lf ^ (lf << 13);
        lf = lf ^ (lf >> 17);
        lf = lf ^ (lf << 5);
        return lf;
    endfunction

    // Monitor: compares each produced frame against the scoreboard queue.
    always @(negedge clk) begin
        if (running && fvalid) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R6 unexpected frame: actual=%h expected=none", frame);
            end else begin
                check_eq(tag_q.pop_front(), frame, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] r;
        init_model();
        rst_n    = 1'b0;
        in_valid = 1'b0;
        samp_a   = '0;
        samp_b   = '0;
        mode     = 2'd0;
        wr_en    = 1'b0;
        wr_addr  = '0;
        wr_id    = '0;
        repeat (3) @(negedge clk);
        check_eq("R6 reset frame zero", frame, '0);
        check_eq("R6 reset valid low", FW'(fvalid), '0);
        rst_n   = 1'b1;
        running = 1'b1;

        send(20'h12345, 20'hABCDE, 2'd0, "R10 first two-wire frame sees zero history");
        send(20'hFEDCB, 20'h0F0F0, 2'd0, "R5 R2 default two-wire with history");
        send(20'h5A5A5, 20'h3C3C3, 2'd1, "R5 default one-wire");
        send(20'h81234, 20'h7EDCB, 2'd2, "R5 default half-wire");
        send(20'hFFFFF, 20'hFFFFF, 2'd3, "R7 off layout all zero");
        send(20'hFFFFF, 20'hFFFFF, 2'd1, "R7 one-wire upper positions zero");
        send(20'h13579, 20'h2468A, 2'd0, "R10 history updated in any layout");
        idle(3);
        check_eq("R6 frame held between strobes", frame, last_exp);
        check_eq("R6 valid low while idle", FW'(fvalid), '0);

        wr(1, 0, code_of(1, 0, 7));
        wr(1, 39, code_of(1, 1, 0));
        wr(2, 5, code_of(1, 0, 19));
        send(20'hF0F0F, 20'h00080, 2'd1, "R1 programmed one-wire");
        send(20'h00001, 20'h80000, 2'd2, "R1 programmed half-wire");

        wr(0, 3, code_of(0, 0, 12));
        wr(0, 50, code_of(0, 1, 19));
        send(20'h80000, 20'h01000, 2'd0, "R2 two-wire previous bits");
        send(20'h00000, 20'h00000, 2'd0, "R2 two-wire previous bits after update");

        wr(1, 2, code_of(0, 1, 5));
        wr(2, 20, code_of(0, 0, 0));
        send(20'hFFFFF, 20'hFFFFF, 2'd1, "R3 previous id in one-wire");
        send(20'hFFFFF, 20'hFFFFF, 2'd2, "R3 previous id in half-wire");

        wr(0, 0, 7'h7F);
        wr(0, 1, 7'h30);
        wr(0, 2, 7'h01);
        wr(0, 4, 7'h2E);
        wr(0, 6, 7'h00);
        send(20'hFFFFF, 20'hFFFFF, 2'd0, "R4 invalid identifiers");

        wr(1, 45, code_of(1, 1, 15));
        wr(3, 5, code_of(1, 1, 15));
        wr(0, 70, code_of(1, 0, 2));
        send(20'hAAAAA, 20'h55555, 2'd1, "R8 one-wire after ignored writes");
        send(20'hAAAAA, 20'h55555, 2'd2, "R8 half-wire untouched");
        send(20'hAAAAA, 20'h55555, 2'd0, "R8 two-wire write applied");

        send_wr(20'h00008, 20'hFFFFF, 2'd1, 1, 10, code_of(1, 1, 3), "R9 same-cycle write uses old table");
        send(20'h00008, 20'h00000, 2'd1, "R9 write visible on next frame");

        for (int i = 0; i < 60; i++) begin
            r = rnd();
            if (r[0]) begin
                logic [6:0] id;
                id = (r[4:1] < 4'd12) ? code_of(r[5], r[6], int'(r[11:7]) % SW) : r[18:12];
                wr(int'(r[21:20]) % 3, int'(r[28:22]) % FW, id);
            end
            r = rnd();
            send(r[19:0], rnd() >> 12, 2'(int'(r[31:30]) % 3), "R1 R2 random frame");
            if (r[25]) idle(1);
        end

        idle(4);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R6 missing frames: actual=%0d pending expected=0", exp_q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule